// File: doc/BRIEF.md
# Seconds Prescaler with Bus-Timed Divider Reset

This block turns a 32.768 kHz clock-enable into the one-per-second tick that drives a real-time clock's calendar. Inside it is a 15-stage binary divider advanced by the incoming enable. Every stage offers a pulse output, so the update interrupt, alarm, frequency output and countdown timer can take their rates from the same chain. The last stage gives the 1 Hz tick.

Software aligns the seconds boundary by writing a self-clearing command bit. The command clears every divider stage except the first. It holds them cleared from the moment the register write is accepted until the bus reports a STOP condition. A START or repeated START seen before the STOP also ends the hold. The first stage keeps toggling throughout, so the undivided phase output never glitches. Because that stage is not cleared, the first seconds tick after release lands either exactly one second later or one 32 kHz period early.

Top module: `rtc_prescaler`

## Requirements
- R1: A write strobe with address 8'h0F and data bit 0 set starts the hold on the next clock edge. A write to any other address, or with data bit 0 clear, leaves the hold state unchanged.
- R2: The readback of the command bit is always 0.
- R3: A STOP indication ends the hold on the next clock edge.
- R4: A START or repeated-START indication ends the hold on the next clock edge.
- R5: While the hold is active, divider stages 1 and above read zero and emit no pulses on `tick_div_o[14:1]`.
- R6: `ph32_o` (stage 0) inverts on every clock that carries `tick_32k_i`, whether or not the hold is active. It stays steady on clocks without the tick. `tick_div_o[0]` keeps pulsing during the hold.
- R7: `tick_div_o[k]` pulses for one clock, one edge after a 32 kHz tick on which divider bits k down to 0 were all ones. Its rate is therefore 32768 / 2^(k+1) per second.
- R8: After the hold ends with stage 0 at phase p, the first `tick_1hz_o` pulse follows exactly 32768 - p ticks. This places it between 32767 and 32768 ticks, that is, between 1000 ms minus 30.5 us and 1000 ms.
- R9: On a clock edge not preceded by a 32 kHz tick, every `tick_div_o` bit is 0 after that edge.
- R10: If a setting write and a START or STOP arrive in the same clock, the write wins and the hold is active after the edge.
- R11: While `rst_n` is low, the divider, all pulses and the hold are 0.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k_i | input | 1 | 32.768 kHz clock-enable, one clock wide |
| wr_stb_i | input | 1 | Register write accepted (data byte acknowledged) |
| wr_addr_i | input | 8 | Register address of the write |
| wr_data_i | input | 8 | Register data of the write |
| bus_start_i | input | 1 | START or repeated-START condition seen |
| bus_stop_i | input | 1 | STOP condition seen |
| ph32_o | output | 1 | Stage 0 level, never cleared by the command |
| tick_div_o | output | 15 | Per-stage pulses; bit k at 32768/2^(k+1) Hz |
| tick_1hz_o | output | 1 | Seconds tick (last stage pulse) |
| chain_held_o | output | 1 | Stages 1 and above are held cleared |
| rst_bit_rd_o | output | 1 | Readback of the command bit |

## Verification
Each command, START and STOP stimulus, and each single 32 kHz tick, shows its effect on `chain_held_o`, `ph32_o` and `tick_div_o` one clock edge later. The bench therefore drives on the falling edge and compares on the next falling edge after exactly one rising edge. The rate checks count pulses over a known number of ticks. The seconds-alignment check counts the ticks delivered after the releasing edge. It stops at the first falling edge where the 1 Hz pulse is visible, and the count must equal 32768 - p. This is done once with p = 0 and once with p = 1.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

  typedef enum logic {
    CMD_IDLE = 1'b0,
    CMD_HELD = 1'b1
  } cmd_state_e;

  // Bit k of the result is set when bits k..0 of v are all ones.
  // A stage carries out (and pulses) exactly when this holds.
  function automatic logic [31:0] ones_prefix(logic [31:0] v);
    logic [31:0] r;
    r[0] = v[0];
    for (int k = 1; k < 32; k++) r[k] = r[k-1] & v[k];
    return r;
  endfunction

  // Any bus framing condition ends a pending divider hold.
  function automatic logic frame_edge(logic start_c, logic stop_c);
    return start_c | stop_c;
  endfunction

endpackage

// File: rtl/rtc_rst_cmd.sv
module rtc_rst_cmd
  import rtc_presc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h0F,
  parameter int unsigned CMD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bus_start_i,
  input  logic              bus_stop_i,
  output logic              held_o,
  output logic              cmd_set_o,
  output logic              release_o
);

  cmd_state_e state_q, state_d;

  assign cmd_set_o = wr_stb_i && (wr_addr_i == CMD_ADDR) && wr_data_i[CMD_BIT];
  assign release_o = frame_edge(bus_start_i, bus_stop_i);

  always_comb begin
    state_d = state_q;
    if (cmd_set_o)
      state_d = CMD_HELD;
    else if (state_q == CMD_HELD && release_o)
      state_d = CMD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CMD_IDLE;
    else        state_q <= state_d;
  end

  assign held_o = (state_q == CMD_HELD);

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_presc_pkg::*;
#(
  parameter int unsigned DIV_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                hold_i,
  output logic [DIV_BITS-1:0] stage_o,
  output logic [DIV_BITS-1:0] tick_o
);

  logic [DIV_BITS-1:0] div_q, div_d;
  logic [DIV_BITS-1:0] tick_q, tick_d;
  logic [DIV_BITS-1:0] carry_w;

  assign carry_w = DIV_BITS'(ones_prefix(32'(div_q)));

  // Stage 0 is free running; stages above it are gated by the hold.
  for (genvar k = 0; k < DIV_BITS; k++) begin : g_stage
    if (k == 0) begin : g_free
      assign tick_d[k] = tick_i & carry_w[k];
    end else begin : g_gated
      assign tick_d[k] = tick_i & carry_w[k] & ~hold_i;
    end
  end

  always_comb begin
    div_d = div_q;
    if (tick_i) div_d = div_q + DIV_BITS'(1);
    if (hold_i) div_d[DIV_BITS-1:1] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= '0;
    end else begin
      div_q  <= div_d;
      tick_q <= tick_d;
    end
  end

  assign stage_o = div_q;
  assign tick_o  = tick_q;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_presc_pkg::*;
#(
  parameter int unsigned DIV_BITS = 15,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h0F,
  parameter int unsigned CMD_BIT  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_32k_i,
  input  logic                wr_stb_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                bus_start_i,
  input  logic                bus_stop_i,
  output logic                ph32_o,
  output logic [DIV_BITS-1:0] tick_div_o,
  output logic                tick_1hz_o,
  output logic                chain_held_o,
  output logic                rst_bit_rd_o
);

  localparam int unsigned TOP_STAGE = DIV_BITS - 1;

  logic                held_w, cmd_set_w, release_w;
  logic [DIV_BITS-1:0] stage_w, tick_w;

  rtc_rst_cmd #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CMD_ADDR(CMD_ADDR),
    .CMD_BIT (CMD_BIT)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb_i   (wr_stb_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .bus_start_i(bus_start_i),
    .bus_stop_i (bus_stop_i),
    .held_o     (held_w),
    .cmd_set_o  (cmd_set_w),
    .release_o  (release_w)
  );

  rtc_div_chain #(
    .DIV_BITS(DIV_BITS)
  ) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_32k_i),
    .hold_i (held_w),
    .stage_o(stage_w),
    .tick_o (tick_w)
  );

  assign ph32_o       = stage_w[0];
  assign tick_div_o   = tick_w;
  assign tick_1hz_o   = tick_w[TOP_STAGE];
  assign chain_held_o = held_w;
  assign rst_bit_rd_o = 1'b0;

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int unsigned DIV_BITS = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_32k_i,
  input logic                bus_start_i,
  input logic                bus_stop_i,
  input logic                cmd_set_w,
  input logic [DIV_BITS-1:0] stage_w,
  input logic                ph32_o,
  input logic [DIV_BITS-1:0] tick_div_o,
  input logic                tick_1hz_o,
  input logic                chain_held_o
);

  AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set_w |=> chain_held_o); // R1
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_held_o && !cmd_set_w) |=> !chain_held_o); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_held_o && bus_stop_i && !cmd_set_w) |=> !chain_held_o); // R3
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_held_o && bus_start_i && !cmd_set_w) |=> !chain_held_o); // R4
  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chain_held_o) |-> (tick_div_o[DIV_BITS-1:1] == '0)); // R5
  AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_held_o && $past(chain_held_o)) |-> (stage_w[DIV_BITS-1:1] == '0)); // R5
  AST_PH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_32k_i |=> (ph32_o != $past(ph32_o))); // R6
  AST_PH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_32k_i |=> $stable(ph32_o)); // R6
  AST_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz_o |-> (stage_w == '0)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_32k_i |=> (tick_div_o == '0)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set_w && (bus_start_i || bus_stop_i)) |=> chain_held_o); // R10

endmodule

bind rtc_prescaler rtc_prescaler_chk #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_32k_i  (tick_32k_i),
  .bus_start_i (bus_start_i),
  .bus_stop_i  (bus_stop_i),
  .cmd_set_w   (cmd_set_w),
  .stage_w     (stage_w),
  .ph32_o      (ph32_o),
  .tick_div_o  (tick_div_o),
  .tick_1hz_o  (tick_1hz_o),
  .chain_held_o(chain_held_o)
);

// File: tb/sim_rtc_prescaler.sv
module sim_rtc_prescaler;

  localparam int unsigned NB = 15;
  localparam int unsigned SECOND = 1 << NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          stb = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    data = '0;
  logic          start_c = 1'b0;
  logic          stop_c = 1'b0;
  logic          ph32;
  logic [NB-1:0] tdiv;
  logic          t1hz;
  logic          held;
  logic          rdbk;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rtc_prescaler #(.DIV_BITS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k_i(tick),
    .wr_stb_i(stb), .wr_addr_i(addr), .wr_data_i(data),
    .bus_start_i(start_c), .bus_stop_i(stop_c),
    .ph32_o(ph32), .tick_div_o(tdiv), .tick_1hz_o(t1hz),
    .chain_held_o(held), .rst_bit_rd_o(rdbk)
  );

  typedef struct packed {
    logic       stb;
    logic [7:0] addr;
    logic [7:0] data;
    logic       start_c;
    logic       stop_c;
    logic       tick;
    logic       e_held;
    logic       e_ph;
    logic       e_t0;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 R7
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{1'b1, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 data bit clear
    '{1'b1, 8'h0E, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 other address
    '{1'b1, 8'h0F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 set
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 held
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 held
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{1'b1, 8'h0F, 8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, 8'h0F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1
    '{1'b1, 8'h0F, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R3
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tick = 1'b0; stb = 1'b0; addr = '0; data = '0;
    start_c = 1'b0; stop_c = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic send_cmd();
    stb = 1'b1; addr = 8'h0F; data = 8'h01;
    step();
    idle_inputs();
  endtask

  // Release with stage 0 at phase p, then count ticks to the first second.
  task automatic second_after_release(logic p);
    int n;
    send_cmd();
    if (ph32 != p) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
    check("R8 phase setup", int'(ph32), int'(p));
    stop_c = 1'b1;
    step();
    stop_c = 1'b0;
    check("R3 release before count", int'(held), 0);
    n = 0;
    tick = 1'b1;
    for (int i = 0; i < SECOND + 8; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (t1hz) break;
    end
    tick = 1'b0;
    check("R8 ticks to first second", n, int'(SECOND) - int'(p));
    check("R8 inside window", int'(n >= int'(SECOND) - 1 && n <= int'(SECOND)), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0, c1, c5, up;
    @(negedge clk);
    idle_inputs();
    step();
    check("R11 reset held", int'(held), 0);
    check("R11 reset pulses", int'(tdiv), 0);
    check("R11 reset phase", int'(ph32), 0);
    rst_n = 1'b1;
    step();

    // Vector table: every row's effect is visible one edge later.
    for (int i = 0; i < NV; i++) begin
      stb = VEC[i].stb; addr = VEC[i].addr; data = VEC[i].data;
      start_c = VEC[i].start_c; stop_c = VEC[i].stop_c; tick = VEC[i].tick;
      step();
      check($sformatf("R1/R3/R4/R10 hold row %0d", i), int'(held), int'(VEC[i].e_held));
      check($sformatf("R6 phase row %0d", i), int'(ph32), int'(VEC[i].e_ph));
      check($sformatf("R7 stage0 pulse row %0d", i), int'(tdiv[0]), int'(VEC[i].e_t0));
      check($sformatf("R2 readback row %0d", i), int'(rdbk), 0);
    end
    idle_inputs();
    step();
    check("R9 no tick no pulse", int'(tdiv), 0);

    // R7 rates over 64 ticks from a cleared divider.
    do_reset();
    c0 = 0; c1 = 0; c5 = 0;
    tick = 1'b1;
    for (int i = 0; i < 64; i++) begin
      step();
      c0 += int'(tdiv[0]); c1 += int'(tdiv[1]); c5 += int'(tdiv[5]);
    end
    tick = 1'b0;
    check("R7 stage0 count", c0, 32);
    check("R7 stage1 count", c1, 16);
    check("R7 stage5 count", c5, 1);

    // R5 / R6 during a long hold.
    send_cmd();
    c0 = 0; up = 0;
    tick = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step();
      c0 += int'(tdiv[0]);
      up += $countones(tdiv[NB-1:1]);
    end
    tick = 1'b0;
    check("R5 upper pulses while held", up, 0);
    check("R6 stage0 pulses while held", c0, 50);
    check("R5 still held", int'(held), 1);
    check("R2 readback while held", int'(rdbk), 0);
    start_c = 1'b1;
    step();
    start_c = 1'b0;
    check("R4 start releases", int'(held), 0);

    second_after_release(1'b0);
    second_after_release(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule